// File: doc/BRIEF.md
# Warp Issue Sequencer with Decoupled Special-Function Co-Issue

This block feeds one 32-lane warp onto two execution resources. The first is a multiply-add datapath that handles 8 lanes per clock. The second is a special-function pipeline that runs beside it. The warp is treated as four lane groups of 8 lanes, and each group keeps its own program position. A group that is held up by a dependency, or by a busy special-function pipeline, falls behind while the other groups keep issuing. The lagging group catches up later. Within each group, instructions still run strictly in order.

A program is loaded into a small descriptor buffer through a write port. Each descriptor holds a unit class, a destination tag and two source tags. A `start` pulse then launches the warp. Each clock the sequencer can issue at most one multiply-add lane group and at most one special-function lane group, and it marks each issue with a one-hot group mask. Both datapaths are modelled as fixed-latency stubs that clear a per-group scoreboard.

Sine-class operations take a multiply-add slot for range reduction and then a special-function slot. The first interpolation of a run is preceded by a one-time reciprocal setup on the special-function pipeline. When every group has passed the end of the program and nothing is left in flight, the block pulses `done` and reports the run length.

Top module: `warp_issue_seq`

## Requirements
- R1: After reset, and while idle, `mad_issue`, `sfu_issue`, `sfu_setup` and `done` are low, and both group masks are zero.
- R2: Each multiply-add issue serves exactly one lane group, and its mask is one-hot. For a program of N mutually independent multiply-add instructions, the run issues on 4·N consecutive clocks, starting with the first running clock.
- R3: A lane group issues its own instructions in program order. An instruction whose source or destination tag is still in flight for that group waits. It may issue MAD_LAT clocks after a multiply-add producer issued, or SFU_LAT clocks after a special-function producer issued.
- R4: Each unit picks, among the groups that are ready for it, the group with the lowest program position. Ties go to the lowest group index. Bit g of a mask stands for lanes 8g to 8g+7.
- R5: In the same clock, one multiply-add issue and one special-function issue may occur, and they always belong to different lane groups.
- R6: A special-function issue happens only in a clock where `sfu_rdy` is high. While `sfu_rdy` is low, the multiply-add unit keeps issuing for groups that are not blocked. This leaves groups at different program positions.
- R7: Unit code 0 is multiply-add and code 1 is logarithm class (special-function only). Code 2 is sine class: a multiply-add issue with `mad_rr` high, followed by a special-function issue once that result has returned. Code 3 is interpolation.
- R8: The first interpolation of a run first causes RCP_CLKS clocks with `sfu_setup` high. The setup starts only in a clock with `sfu_rdy` high, and it happens once per run. After that, each interpolation takes one special-function clock per lane group.
- R9: When all groups have passed `prog_len - 1` and no result is in flight, `done` is high for exactly one clock. In that clock `total_cycles` equals the number of running clocks, counted from the first clock after `start` up to and including the finishing clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write one program descriptor |
| ld_addr | input | 4 | Descriptor slot to write |
| ld_unit | input | 2 | Unit class code (see R7) |
| ld_dst | input | 4 | Destination register tag |
| ld_src_a | input | 4 | First source register tag |
| ld_src_b | input | 4 | Second source register tag |
| start | input | 1 | Launch the warp (ignored while running) |
| prog_len | input | 5 | Number of program instructions, sampled at start |
| sfu_rdy | input | 1 | Special-function pipeline accepts a lane group |
| mad_issue | output | 1 | Multiply-add issue strobe |
| mad_grp | output | 4 | One-hot lane-group mask of the multiply-add issue |
| mad_pc | output | 5 | Program index of the multiply-add issue |
| mad_rr | output | 1 | Issue is the range-reduction part of a sine-class op |
| sfu_issue | output | 1 | Special-function issue strobe |
| sfu_grp | output | 4 | One-hot lane-group mask of the special-function issue |
| sfu_pc | output | 5 | Program index of the special-function issue |
| sfu_setup | output | 1 | Reciprocal setup occupies the special-function pipeline |
| done | output | 1 | One-clock completion pulse |
| total_cycles | output | 16 | Run length, valid with `done` |

## Verification
The hardest state to reach is the one where lane groups of a single warp stand at different program positions. In that state a vector instruction is split around an unrelated scalar operation, and a lagging group must later catch up without overtaking its own dependencies. The bench gets there by holding `sfu_rdy` low for a window while special-function and multiply-add work are interleaved. Some groups then stall on their special-function op, while others run ahead on independent multiply-add work. A cycle-level reference scheduler in the bench predicts every issue event, and the run length, for each program and `sfu_rdy` pattern.

// File: rtl/warp_seq_pkg.sv
// Shared types for the warp issue sequencer.
// Assumes register tags are TAG_W bits wide; unit classes use a 2-bit code.
package warp_seq_pkg;
    parameter int TAG_W = 4;

    typedef enum logic [1:0] {
        U_MAD    = 2'd0,
        U_LOG    = 2'd1,
        U_SIN    = 2'd2,
        U_INTERP = 2'd3
    } unit_e;

    typedef struct packed {
        unit_e              unit;
        logic [TAG_W-1:0]   dst;
        logic [TAG_W-1:0]   src_a;
        logic [TAG_W-1:0]   src_b;
    } desc_t;
endpackage

// File: rtl/warp_prog_buf.sv
// Program descriptor store with one write port and one read port per lane group.
// Assumes reads at an index of DEPTH or more return an all-zero descriptor.
module warp_prog_buf
    import warp_seq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NGRP  = 4,
    parameter int PCW   = 5
) (
    input  logic                               clk,
    input  logic                               wr_en,
    input  logic [$clog2(DEPTH)-1:0]           wr_addr,
    input  desc_t                              wr_data,
    input  logic [NGRP-1:0][PCW-1:0]           rd_addr,
    output logic [NGRP-1:0][$bits(desc_t)-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);

    desc_t mem [DEPTH];

    // Store a descriptor on a write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // One read port per lane group.
    for (genvar g = 0; g < NGRP; g++) begin : g_rd
        always_comb begin
            if (rd_addr[g] < PCW'(DEPTH)) rd_data[g] = mem[rd_addr[g][AW-1:0]];
            else                          rd_data[g] = '0;
        end
    end
endmodule

// File: rtl/warp_lat_pipe.sv
// Fixed-latency datapath stub. An entry inserted in clock t is presented at
// the output during clock t+LAT-1, so its consumer may issue at t+LAT.
// Assumes LAT >= 2.
module warp_lat_pipe #(
    parameter int LAT = 4,
    parameter int GW  = 2,
    parameter int TW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [GW-1:0] in_grp,
    input  logic [TW-1:0] in_tag,
    output logic          out_vld,
    output logic [GW-1:0] out_grp,
    output logic [TW-1:0] out_tag
);
    localparam int ST = LAT - 1;

    logic [ST-1:0]         vld;
    logic [ST-1:0][GW-1:0] grp;
    logic [ST-1:0][TW-1:0] tag;

    // First stage captures the new issue.
    always_ff @(posedge clk) begin
        if (!rst_n) vld[0] <= 1'b0;
        else        vld[0] <= in_vld;
        grp[0] <= in_grp;
        tag[0] <= in_tag;
    end

    // Remaining stages shift the entry toward completion.
    for (genvar i = 1; i < ST; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) vld[i] <= 1'b0;
            else        vld[i] <= vld[i-1];
            grp[i] <= grp[i-1];
            tag[i] <= tag[i-1];
        end
    end

    assign out_vld = vld[ST-1];
    assign out_grp = grp[ST-1];
    assign out_tag = tag[ST-1];
endmodule

// File: rtl/warp_scoreboard.sv
// Per-lane-group pending bits on register tags. Two issue ports set bits and
// two completion ports clear them. Assumes a set and a clear never hit the
// same bit in one clock (issue is blocked while the destination is pending).
module warp_scoreboard #(
    parameter int NGRP = 4,
    parameter int NTAG = 16,
    parameter int GW   = 2,
    parameter int TW   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set0_vld,
    input  logic [GW-1:0]               set0_grp,
    input  logic [TW-1:0]               set0_tag,
    input  logic                        set1_vld,
    input  logic [GW-1:0]               set1_grp,
    input  logic [TW-1:0]               set1_tag,
    input  logic                        clr0_vld,
    input  logic [GW-1:0]               clr0_grp,
    input  logic [TW-1:0]               clr0_tag,
    input  logic                        clr1_vld,
    input  logic [GW-1:0]               clr1_grp,
    input  logic [TW-1:0]               clr1_tag,
    output logic [NGRP-1:0][NTAG-1:0]   pend
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [NTAG-1:0] set_m, clr_m;

        // Decode the set and clear requests that target this group.
        always_comb begin
            set_m = '0;
            clr_m = '0;
            if (set0_vld && set0_grp == GW'(g)) set_m[set0_tag] = 1'b1;
            if (set1_vld && set1_grp == GW'(g)) set_m[set1_tag] = 1'b1;
            if (clr0_vld && clr0_grp == GW'(g)) clr_m[clr0_tag] = 1'b1;
            if (clr1_vld && clr1_grp == GW'(g)) clr_m[clr1_tag] = 1'b1;
        end

        // Update this group's pending bits.
        always_ff @(posedge clk) begin
            if (!rst_n) pend[g] <= '0;
            else        pend[g] <= (pend[g] | set_m) & ~clr_m;
        end
    end
endmodule

// File: rtl/warp_pick.sv
// Oldest-first selector: among candidate groups, picks the lowest program
// position, with ties broken toward the lowest group index.
module warp_pick #(
    parameter int NGRP = 4,
    parameter int PCW  = 5,
    parameter int GW   = 2
) (
    input  logic [NGRP-1:0]          cand,
    input  logic [NGRP-1:0][PCW-1:0] pos,
    output logic                     found,
    output logic [GW-1:0]            sel
);
    // Linear scan; a strict compare keeps the earlier group on a tie.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (cand[g] && (!found || pos[g] < pos[sel])) begin
                found = 1'b1;
                sel   = GW'(g);
            end
        end
    end
endmodule

// File: rtl/warp_issue_seq.sv
// Warp issue sequencer. Splits a warp into lane groups, each with its own
// program counter, and issues each clock at most one multiply-add group and
// one special-function group. Sine-class ops take a range-reduction slot on
// the multiply-add unit first. The first interpolation of a run is preceded
// by a reciprocal setup on the special-function pipeline.
// Assumes the program is loaded before start and is not rewritten while running.
module warp_issue_seq
    import warp_seq_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int LANES         = 32,
    parameter int LANES_PER_CLK = 8,
    parameter int MAD_LAT       = 4,
    parameter int SFU_LAT       = 8,
    parameter int RCP_CLKS      = 4,
    parameter int CNT_W         = 16,
    localparam int NGRP = LANES / LANES_PER_CLK,
    localparam int PCW  = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_addr,
    input  logic [1:0]        ld_unit,
    input  logic [TAG_W-1:0]  ld_dst,
    input  logic [TAG_W-1:0]  ld_src_a,
    input  logic [TAG_W-1:0]  ld_src_b,
    input  logic              start,
    input  logic [PCW-1:0]    prog_len,
    input  logic              sfu_rdy,
    output logic              mad_issue,
    output logic [NGRP-1:0]   mad_grp,
    output logic [PCW-1:0]    mad_pc,
    output logic              mad_rr,
    output logic              sfu_issue,
    output logic [NGRP-1:0]   sfu_grp,
    output logic [PCW-1:0]    sfu_pc,
    output logic              sfu_setup,
    output logic              done,
    output logic [CNT_W-1:0]  total_cycles
);
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int NTAG = 1 << TAG_W;
    localparam int RCW  = $clog2(RCP_CLKS + 1);
    localparam int DW   = $bits(desc_t);

    logic                          running;
    logic [PCW-1:0]                len_q;
    logic [NGRP-1:0][PCW-1:0]      pc;
    logic [NGRP-1:0]               stage;
    logic [NGRP-1:0][DW-1:0]       rd_raw;
    desc_t                         cur [NGRP];
    logic [NGRP-1:0][NTAG-1:0]     pend;
    logic                          rcp_done;
    logic [RCW-1:0]                rcp_left;
    logic [CNT_W-1:0]              cyc;

    logic [NGRP-1:0] mad_cand, sfu_cand;
    logic            mad_found, sfu_found;
    logic [GW-1:0]   mad_sel, sfu_sel;
    logic            need_setup, setup_now, sfu_go, mad_go, finished;

    logic            mp_vld, sp_vld;
    logic [GW-1:0]   mp_grp, sp_grp;
    logic [TAG_W-1:0] mp_tag, sp_tag;

    desc_t wr_desc;
    assign wr_desc = '{unit: unit_e'(ld_unit), dst: ld_dst, src_a: ld_src_a, src_b: ld_src_b};

    warp_prog_buf #(.DEPTH(DEPTH), .NGRP(NGRP), .PCW(PCW)) u_buf (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (wr_desc),
        .rd_addr (pc),
        .rd_data (rd_raw)
    );

    // Per-group readiness for each unit.
    for (genvar g = 0; g < NGRP; g++) begin : g_ready
        logic act, hz;
        assign cur[g] = desc_t'(rd_raw[g]);
        always_comb begin
            act = running && (pc[g] < len_q);
            hz  = pend[g][cur[g].src_a] | pend[g][cur[g].src_b] | pend[g][cur[g].dst];
            mad_cand[g] = act && !stage[g] && !hz &&
                          (cur[g].unit == U_MAD || cur[g].unit == U_SIN);
            if (stage[g])
                sfu_cand[g] = act && !pend[g][cur[g].dst];
            else
                sfu_cand[g] = act && !hz &&
                              (cur[g].unit == U_LOG || cur[g].unit == U_INTERP);
        end
    end

    warp_pick #(.NGRP(NGRP), .PCW(PCW), .GW(GW)) u_pick_mad (
        .cand (mad_cand), .pos (pc), .found (mad_found), .sel (mad_sel)
    );

    warp_pick #(.NGRP(NGRP), .PCW(PCW), .GW(GW)) u_pick_sfu (
        .cand (sfu_cand), .pos (pc), .found (sfu_found), .sel (sfu_sel)
    );

    // Special-function arbitration between reciprocal setup and normal issue.
    always_comb begin
        need_setup = sfu_found && !stage[sfu_sel] &&
                     cur[sfu_sel].unit == U_INTERP && !rcp_done;
        setup_now  = running && ((rcp_left != '0) || (sfu_rdy && need_setup));
        sfu_go     = running && (rcp_left == '0) && sfu_rdy && sfu_found && !need_setup;
        mad_go     = mad_found;
        finished   = running && (pend == '0);
        for (int g = 0; g < NGRP; g++)
            if (pc[g] != len_q) finished = 1'b0;
    end

    // Drive the issue ports.
    always_comb begin
        mad_issue = mad_go;
        mad_grp   = mad_go ? (NGRP'(1) << mad_sel) : '0;
        mad_pc    = pc[mad_sel];
        mad_rr    = mad_go && (cur[mad_sel].unit == U_SIN);
        sfu_issue = sfu_go;
        sfu_grp   = sfu_go ? (NGRP'(1) << sfu_sel) : '0;
        sfu_pc    = pc[sfu_sel];
        sfu_setup = setup_now;
    end

    // Run control, cycle count and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running      <= 1'b0;
            len_q        <= '0;
            cyc          <= '0;
            done         <= 1'b0;
            total_cycles <= '0;
        end else begin
            done <= 1'b0;
            if (!running) begin
                if (start) begin
                    running <= 1'b1;
                    len_q   <= prog_len;
                    cyc     <= '0;
                end
            end else begin
                cyc <= cyc + 1'b1;
                if (finished) begin
                    running      <= 1'b0;
                    done         <= 1'b1;
                    total_cycles <= cyc + 1'b1;
                end
            end
        end
    end

    // Per-group program counters and sine-class stage flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            stage <= '0;
        end else if (!running) begin
            if (start) begin
                pc    <= '0;
                stage <= '0;
            end
        end else begin
            if (mad_go) begin
                if (cur[mad_sel].unit == U_SIN) stage[mad_sel] <= 1'b1;
                else                            pc[mad_sel] <= pc[mad_sel] + 1'b1;
            end
            if (sfu_go) begin
                stage[sfu_sel] <= 1'b0;
                pc[sfu_sel]    <= pc[sfu_sel] + 1'b1;
            end
        end
    end

    // One-time reciprocal setup sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcp_done <= 1'b0;
            rcp_left <= '0;
        end else if (!running) begin
            if (start) begin
                rcp_done <= 1'b0;
                rcp_left <= '0;
            end
        end else if (setup_now) begin
            if (rcp_left == '0) begin
                rcp_left <= RCW'(RCP_CLKS - 1);
                if (RCP_CLKS == 1) rcp_done <= 1'b1;
            end else begin
                rcp_left <= rcp_left - 1'b1;
                if (rcp_left == RCW'(1)) rcp_done <= 1'b1;
            end
        end
    end

    warp_lat_pipe #(.LAT(MAD_LAT), .GW(GW), .TW(TAG_W)) u_mad_pipe (
        .clk (clk), .rst_n (rst_n),
        .in_vld (mad_go), .in_grp (mad_sel), .in_tag (cur[mad_sel].dst),
        .out_vld (mp_vld), .out_grp (mp_grp), .out_tag (mp_tag)
    );

    warp_lat_pipe #(.LAT(SFU_LAT), .GW(GW), .TW(TAG_W)) u_sfu_pipe (
        .clk (clk), .rst_n (rst_n),
        .in_vld (sfu_go), .in_grp (sfu_sel), .in_tag (cur[sfu_sel].dst),
        .out_vld (sp_vld), .out_grp (sp_grp), .out_tag (sp_tag)
    );

    warp_scoreboard #(.NGRP(NGRP), .NTAG(NTAG), .GW(GW), .TW(TAG_W)) u_sb (
        .clk (clk), .rst_n (rst_n),
        .set0_vld (mad_go), .set0_grp (mad_sel), .set0_tag (cur[mad_sel].dst),
        .set1_vld (sfu_go), .set1_grp (sfu_sel), .set1_tag (cur[sfu_sel].dst),
        .clr0_vld (mp_vld), .clr0_grp (mp_grp),  .clr0_tag (mp_tag),
        .clr1_vld (sp_vld), .clr1_grp (sp_grp),  .clr1_tag (sp_tag),
        .pend (pend)
    );
endmodule

// File: rtl/warp_issue_seq_chk.sv
// Protocol checker for the warp issue sequencer, attached by bind.
// Observes only the top-level ports.
module warp_issue_seq_chk #(
    parameter int NGRP = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sfu_rdy,
    input logic            mad_issue,
    input logic [NGRP-1:0] mad_grp,
    input logic            sfu_issue,
    input logic [NGRP-1:0] sfu_grp,
    input logic            sfu_setup,
    input logic            done
);
    // R2
    mad_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mad_issue |-> $countones(mad_grp) == 1);

    // R1
    mad_idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mad_issue |-> mad_grp == '0);

    // R5
    unit_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mad_grp & sfu_grp) == '0);

    // R6
    sfu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfu_issue |-> (sfu_rdy && $countones(sfu_grp) == 1));

    // R8
    setup_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sfu_setup |-> !sfu_issue);

    // R8
    setup_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sfu_setup) |-> sfu_rdy);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mad_issue && !sfu_issue && !sfu_setup));
endmodule

bind warp_issue_seq warp_issue_seq_chk #(.NGRP(NGRP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfu_rdy   (sfu_rdy),
    .mad_issue (mad_issue),
    .mad_grp   (mad_grp),
    .sfu_issue (sfu_issue),
    .sfu_grp   (sfu_grp),
    .sfu_setup (sfu_setup),
    .done      (done)
);

// File: tb/warp_issue_seq_bench.sv
// Scoreboard bench: a reference scheduler task pushes expected issue events
// into a queue; the run loop monitors the ports each clock and compares.
module warp_issue_seq_bench;
    localparam int CLK_NS   = 10;
    localparam int MAD_LAT  = 4;
    localparam int SFU_LAT  = 8;
    localparam int RCP_CLKS = 4;
    localparam int NG       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_addr = '0;
    logic [1:0]  ld_unit = '0;
    logic [3:0]  ld_dst = '0, ld_src_a = '0, ld_src_b = '0;
    logic        start = 1'b0;
    logic [4:0]  prog_len = '0;
    logic        sfu_rdy = 1'b1;
    logic        mad_issue, mad_rr, sfu_issue, sfu_setup, done;
    logic [3:0]  mad_grp, sfu_grp;
    logic [4:0]  mad_pc, sfu_pc;
    logic [15:0] total_cycles;

    warp_issue_seq u_warp_issue_seq (
        .clk (clk), .rst_n (rst_n), .ld_en (ld_en), .ld_addr (ld_addr),
        .ld_unit (ld_unit), .ld_dst (ld_dst), .ld_src_a (ld_src_a),
        .ld_src_b (ld_src_b), .start (start), .prog_len (prog_len),
        .sfu_rdy (sfu_rdy), .mad_issue (mad_issue), .mad_grp (mad_grp),
        .mad_pc (mad_pc), .mad_rr (mad_rr), .sfu_issue (sfu_issue),
        .sfu_grp (sfu_grp), .sfu_pc (sfu_pc), .sfu_setup (sfu_setup),
        .done (done), .total_cycles (total_cycles)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int q[$];
    int pu[16], pd[16], pa[16], pb[16];
    int plen = 0;
    int lo_a = 0, lo_b = 0;
    int exp_total = 0;
    int obs_rr = 0, obs_setup = 0, obs_sfu = 0, obs_mad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit rdy_at(input int c);
        return !(c >= lo_a && c < lo_b);
    endfunction

    function automatic int grp_idx(input logic [3:0] m);
        for (int i = 0; i < NG; i++) if (m[i]) return i;
        return 0;
    endfunction

    task automatic prog_clear();
        plen = 0;
    endtask

    task automatic prog_add(input int u, input int d, input int a, input int b);
        pu[plen] = u; pd[plen] = d; pa[plen] = a; pb[plen] = b;
        plen++;
    endtask

    // Reference scheduler: event = cycle<<9 | kind<<7 | grp<<5 | pc,
    // kind 0 mad, 1 mad range-reduce, 2 sfu, 3 setup.
    task automatic model();
        int pc[NG], stg[NG], rdy[NG][16];
        int rcp_done, left, bm, bs, u;
        bit hz, sfu_ev;
        q.delete();
        rcp_done = 0; left = 0; exp_total = -1;
        for (int g = 0; g < NG; g++) begin
            pc[g] = 0; stg[g] = 0;
            for (int t = 0; t < 16; t++) rdy[g][t] = 0;
        end
        for (int c = 0; c < 3000; c++) begin
            bit fin;
            fin = 1'b1;
            for (int g = 0; g < NG; g++) begin
                if (pc[g] != plen) fin = 1'b0;
                for (int t = 0; t < 16; t++) if (rdy[g][t] > c) fin = 1'b0;
            end
            if (fin) begin exp_total = c + 1; break; end
            bm = -1; bs = -1;
            for (int g = 0; g < NG; g++) begin
                if (pc[g] < plen) begin
                    u  = pu[pc[g]];
                    hz = rdy[g][pa[pc[g]]] > c || rdy[g][pb[pc[g]]] > c ||
                         rdy[g][pd[pc[g]]] > c;
                    if (!stg[g] && !hz && (u == 0 || u == 2))
                        if (bm < 0 || pc[g] < pc[bm]) bm = g;
                    if ((stg[g] && rdy[g][pd[pc[g]]] <= c) ||
                        (!stg[g] && !hz && (u == 1 || u == 3)))
                        if (bs < 0 || pc[g] < pc[bs]) bs = g;
                end
            end
            if (bm >= 0)
                q.push_back((c << 9) | ((pu[pc[bm]] == 2 ? 1 : 0) << 7) | (bm << 5) | pc[bm]);
            sfu_ev = 1'b0;
            if (left > 0) begin
                q.push_back((c << 9) | (3 << 7));
                left--;
                if (left == 0) rcp_done = 1;
            end else if (rdy_at(c) && bs >= 0) begin
                if (pu[pc[bs]] == 3 && !stg[bs] && !rcp_done) begin
                    q.push_back((c << 9) | (3 << 7));
                    left = RCP_CLKS - 1;
                    if (left == 0) rcp_done = 1;
                end else begin
                    q.push_back((c << 9) | (2 << 7) | (bs << 5) | pc[bs]);
                    sfu_ev = 1'b1;
                end
            end
            if (bm >= 0) begin
                rdy[bm][pd[pc[bm]]] = c + MAD_LAT;
                if (pu[pc[bm]] == 2) stg[bm] = 1; else pc[bm]++;
            end
            if (sfu_ev) begin
                rdy[bs][pd[pc[bs]]] = c + SFU_LAT;
                stg[bs] = 0;
                pc[bs]++;
            end
        end
    endtask

    // Driver: load program, predict, launch; monitor: compare each clock.
    task automatic run(input string tag);
        int rel;
        int obs[$], exp[$];
        bit seen;
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 4'(i); ld_unit = 2'(pu[i]);
            ld_dst = 4'(pd[i]); ld_src_a = 4'(pa[i]); ld_src_b = 4'(pb[i]);
        end
        @(negedge clk);
        ld_en = 1'b0;
        model();
        prog_len = 5'(plen);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        obs_rr = 0; obs_setup = 0; obs_sfu = 0; obs_mad = 0;
        rel = 0; seen = 1'b0;
        while (rel < 3000) begin
            sfu_rdy = rdy_at(rel);
            #1;
            if (done) begin
                seen = 1'b1;
                chk(rel == exp_total, tag, "R9 done clock", rel, exp_total);
                chk(int'(total_cycles) == exp_total, tag, "R9 total_cycles",
                    int'(total_cycles), exp_total);
                break;
            end
            obs.delete(); exp.delete();
            if (mad_issue) begin
                obs.push_back((rel << 9) | ((mad_rr ? 1 : 0) << 7) |
                              (grp_idx(mad_grp) << 5) | int'(mad_pc));
                obs_mad++;
                if (mad_rr) obs_rr++;
            end
            if (sfu_setup) begin obs.push_back((rel << 9) | (3 << 7)); obs_setup++; end
            if (sfu_issue) begin
                obs.push_back((rel << 9) | (2 << 7) | (grp_idx(sfu_grp) << 5) | int'(sfu_pc));
                obs_sfu++;
            end
            while (q.size() > 0 && (q[0] >> 9) == rel) exp.push_back(q.pop_front());
            if (obs.size() != 0 || exp.size() != 0) begin
                chk(obs.size() == exp.size(), tag, "R4 event count in clock",
                    obs.size(), exp.size());
                for (int i = 0; i < obs.size() && i < exp.size(); i++)
                    chk(obs[i] == exp[i], tag, "R4 issue event (cyc<<9|kind<<7|grp<<5|pc)",
                        obs[i], exp[i]);
            end
            rel++;
            @(negedge clk);
        end
        chk(seen, tag, "R9 done seen", seen, 1);
        chk(q.size() == 0, tag, "unconsumed expected events", q.size(), 0);
        @(negedge clk);
        chk(!done, tag, "R9 done single clock", done, 0);
        sfu_rdy = 1'b1;
        lo_a = 0; lo_b = 0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!mad_issue && !sfu_issue && !sfu_setup && !done && mad_grp == 0 && sfu_grp == 0,
            "R1", "outputs in reset", {mad_issue, sfu_issue, sfu_setup, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!mad_issue && !sfu_issue && !sfu_setup && !done, "R1", "outputs idle",
            {mad_issue, sfu_issue, sfu_setup, done}, 0);

        // R2 independent multiply-add stream: 12 issue clocks, finish after drain
        prog_clear();
        prog_add(0, 1, 0, 0); prog_add(0, 2, 0, 0); prog_add(0, 3, 0, 0);
        run("R2");
        chk(obs_mad == 12, "R2", "mad issue clocks", obs_mad, 12);
        chk(exp_total == 16, "R2", "hand-computed run length", exp_total, 16);

        // R3 dependent logarithm chain on the special-function unit
        prog_clear();
        prog_add(1, 1, 0, 0); prog_add(1, 2, 1, 1); prog_add(0, 3, 2, 0);
        run("R3");

        // R5 / R7 interleaved dependent mix with sine class
        prog_clear();
        prog_add(0, 1, 0, 0); prog_add(1, 2, 1, 0); prog_add(0, 3, 0, 0);
        prog_add(2, 4, 3, 3); prog_add(0, 5, 2, 4); prog_add(0, 6, 0, 0);
        run("R5");
        chk(obs_rr == 4, "R7", "range-reduce mad issues", obs_rr, 4);
        chk(obs_sfu == 8, "R7", "sfu issues for log+sine", obs_sfu, 8);

        // R8 interpolation with reciprocal setup once per run
        prog_clear();
        prog_add(3, 1, 0, 0); prog_add(0, 2, 1, 1); prog_add(3, 3, 0, 0);
        run("R8");
        chk(obs_setup == RCP_CLKS, "R8", "setup clocks", obs_setup, RCP_CLKS);
        chk(obs_sfu == 8, "R8", "interp sfu clocks", obs_sfu, 8);

        // R6 split vector around a stalled special-function op
        prog_clear();
        prog_add(0, 1, 0, 0); prog_add(1, 2, 0, 0); prog_add(0, 3, 1, 0);
        prog_add(0, 4, 0, 0); prog_add(1, 5, 3, 0); prog_add(0, 6, 4, 2);
        lo_a = 2; lo_b = 11;
        run("R6");

        // R8 setup delayed by sfu_rdy low at the first interpolation
        prog_clear();
        prog_add(0, 1, 0, 0); prog_add(3, 2, 0, 0); prog_add(0, 3, 2, 1);
        lo_a = 0; lo_b = 6;
        run("R8");
        chk(obs_setup == RCP_CLKS, "R8", "setup clocks with late ready", obs_setup, RCP_CLKS);

        // R9 empty program
        prog_clear();
        run("R9");
        chk(exp_total == 1, "R9", "empty program run length", exp_total, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule